// File: doc/BRIEF.md
# Clock Status Interrupt Register Unit

This block is the interrupt-enable and oscillator-status register slice of a clock management unit. It holds three request enables: a periodic real-time tick, PLL lock, and oscillator status change. It also holds a sticky flag that records any change of the oscillator-qualified status, and a read-only copy of that status. Software reaches these registers over a simple synchronous register bus. Writes take effect on the clock edge. Reads return data combinationally from the presented address.

The block registers the oscillator-qualified status once. It compares the registered value with its previous value, and any toggle in either direction sets the change flag. Software clears the flag by writing a one to its bit. Entering full stop mode forces the registered status low, so the stop entry can itself raise the flag. Each of the three interrupt request lines is its source flag gated by its enable bit. The tick and lock flags are held elsewhere and arrive here already latched. A gate enable for the oscillator clock to a peripheral follows the registered status, so that clock is held off while the oscillator is unqualified.

Top module: `clkstat_irq_regs`

## Requirements
- R1: After reset, the enable register reads 0x00, the status register reads 0x00, and all three request lines and the clock gate enable are low.
- R2: The enable register is at address 0x38. Bit 7 (tick), bit 4 (lock) and bit 1 (oscillator) are writable and read back as written. Every other bit reads 0 whatever is written.
- R3: The oscillator change flag (status register at 0x37, bit 1) is set by the second rising clock edge after the qualified-status input changes. This holds for both rising and falling changes.
- R4: Writing 0x37 with bit 1 set clears the change flag. Writing 0x37 with bit 1 clear leaves the flag unchanged.
- R5: Status register bit 0 shows the qualified-status input as registered one clock earlier. Writes to bit 0 have no effect.
- R6: While the stop-entry input is high at a clock edge, status bit 0 becomes 0 after that edge, whatever the qualified-status input is.
- R7: Each request line is high exactly when its source flag is set and its enable bit is 1. The pairs are: tick flag with bit 7, lock flag with bit 4, oscillator change flag with bit 1.
- R8: The oscillator clock gate enable is low whenever status bit 0 is 0, and high whenever it is 1.
- R9: When a status change and a clearing write to the flag occur at the same edge, the flag ends up set.
- R10: Bits 7 to 2 of the status register always read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (0 for unmapped addresses) |
| osc_ok_in | input | 1 | Oscillator-qualified status from the qualifier |
| stop_entry | input | 1 | Full stop mode entry indication |
| tick_flag_in | input | 1 | Latched real-time tick flag |
| lock_flag_in | input | 1 | Latched PLL lock flag |
| tick_irq | output | 1 | Real-time tick interrupt request |
| lock_irq | output | 1 | PLL lock interrupt request |
| osc_irq | output | 1 | Oscillator status change interrupt request |
| osc_gclk_en | output | 1 | Gate enable for the oscillator clock to a peripheral |

## Verification
The assertions check the flag rules on every cycle: set after a detected change, held when nothing acts on it, cleared by a clearing write, and set-wins over a clear. They also check the stop-entry override, the clock gate following the status, request lines never high without their flag, and the reserved enable bits staying zero. Only the bench scenarios can show the programmer-visible address map and read-back values. The same holds for the exact latency from an input toggle to the flag. The full sweep of enable values against flag combinations on the request lines is also left to the bench.

// File: rtl/clkstat_pkg.sv
package clkstat_pkg;
  localparam int DW = 8;

  // Enable register bit positions
  localparam int EN_TICK_BIT = 7;
  localparam int EN_LOCK_BIT = 4;
  localparam int EN_OSC_BIT  = 1;

  // Status register bit positions
  localparam int ST_FLAG_BIT = 1;
  localparam int ST_QUAL_BIT = 0;

  // Interrupt source indices
  localparam int SRC_TICK = 0;
  localparam int SRC_LOCK = 1;
  localparam int SRC_OSC  = 2;
  localparam int NSRC     = 3;

  typedef logic [DW-1:0] word_t;

  function automatic word_t en_mask();
    word_t m;
    m = '0;
    m[EN_TICK_BIT] = 1'b1;
    m[EN_LOCK_BIT] = 1'b1;
    m[EN_OSC_BIT]  = 1'b1;
    return m;
  endfunction

  function automatic word_t w1c_mask();
    word_t m;
    m = '0;
    m[ST_FLAG_BIT] = 1'b1;
    return m;
  endfunction

  // Sticky flag update; a set in the same cycle overrides a clear
  function automatic logic flag_next(logic cur, logic set, logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  function automatic word_t stat_word(logic flag, logic qual);
    word_t w;
    w = '0;
    w[ST_FLAG_BIT] = flag;
    w[ST_QUAL_BIT] = qual;
    return w;
  endfunction
endpackage

// File: rtl/clkstat_edge.sv
module clkstat_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic qual_in,
  input  logic force_low,
  output logic qual_q,
  output logic change
);
  logic qual_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q <= 1'b0;
      qual_d <= 1'b0;
    end else begin
      qual_q <= force_low ? 1'b0 : qual_in;
      qual_d <= qual_q;
    end
  end

  assign change = qual_q ^ qual_d;
endmodule

// File: rtl/clkstat_regfile.sv
module clkstat_regfile
  import clkstat_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 'h38,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  word_t             bus_wdata,
  input  logic              osc_chg,
  input  logic              qual_q,
  output word_t             bus_rdata,
  output word_t             en_q,
  output logic              osc_flag,
  output logic              flag_clr
);
  logic wr_en_reg;
  logic wr_stat_reg;

  assign wr_en_reg   = bus_sel & bus_wr & (bus_addr == EN_ADDR);
  assign wr_stat_reg = bus_sel & bus_wr & (bus_addr == STAT_ADDR);
  assign flag_clr    = wr_stat_reg & (|(bus_wdata & w1c_mask()));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en_reg) begin
      en_q <= bus_wdata & en_mask();
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_flag <= 1'b0;
    end else begin
      osc_flag <= flag_next(osc_flag, osc_chg, flag_clr);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == EN_ADDR)        bus_rdata = en_q;
      else if (bus_addr == STAT_ADDR) bus_rdata = stat_word(osc_flag, qual_q);
    end
  end
endmodule

// File: rtl/clkstat_gate.sv
module clkstat_gate #(
  parameter int N = 3
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic [N-1:0] reqs
);
  for (genvar i = 0; i < N; i++) begin : g_src
    assign reqs[i] = flags[i] & enables[i];
  end
endmodule

// File: rtl/clkstat_irq_regs.sv
module clkstat_irq_regs
  import clkstat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 'h38,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              osc_ok_in,
  input  logic              stop_entry,
  input  logic              tick_flag_in,
  input  logic              lock_flag_in,
  output logic              tick_irq,
  output logic              lock_irq,
  output logic              osc_irq,
  output logic              osc_gclk_en
);
  logic        osc_status;
  logic        osc_chg;
  logic        osc_flag;
  logic        flag_clr;
  word_t       en_q;
  logic [NSRC-1:0] src_flags;
  logic [NSRC-1:0] src_ens;
  logic [NSRC-1:0] src_reqs;

  clkstat_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .qual_in   (osc_ok_in),
    .force_low (stop_entry),
    .qual_q    (osc_status),
    .change    (osc_chg)
  );

  clkstat_regfile #(
    .ADDR_W    (ADDR_W),
    .EN_ADDR   (EN_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .osc_chg   (osc_chg),
    .qual_q    (osc_status),
    .bus_rdata (bus_rdata),
    .en_q      (en_q),
    .osc_flag  (osc_flag),
    .flag_clr  (flag_clr)
  );

  assign src_flags[SRC_TICK] = tick_flag_in;
  assign src_flags[SRC_LOCK] = lock_flag_in;
  assign src_flags[SRC_OSC]  = osc_flag;
  assign src_ens[SRC_TICK]   = en_q[EN_TICK_BIT];
  assign src_ens[SRC_LOCK]   = en_q[EN_LOCK_BIT];
  assign src_ens[SRC_OSC]    = en_q[EN_OSC_BIT];

  clkstat_gate #(.N(NSRC)) u_gate (
    .flags   (src_flags),
    .enables (src_ens),
    .reqs    (src_reqs)
  );

  assign tick_irq    = src_reqs[SRC_TICK];
  assign lock_irq    = src_reqs[SRC_LOCK];
  assign osc_irq     = src_reqs[SRC_OSC];
  assign osc_gclk_en = osc_status;
endmodule

// File: rtl/clkstat_irq_regs_chk.sv
module clkstat_irq_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_entry,
  input logic       tick_flag_in,
  input logic       lock_flag_in,
  input logic       tick_irq,
  input logic       lock_irq,
  input logic       osc_irq,
  input logic       osc_gclk_en,
  input logic       osc_status,
  input logic       osc_chg,
  input logic       osc_flag,
  input logic       flag_clr,
  input logic [7:0] en_q
);
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    osc_chg |=> osc_flag);

  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_flag && !flag_clr) |=> osc_flag);

  p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !osc_chg) |=> !osc_flag);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && osc_chg) |=> osc_flag);

  p_stop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_entry |=> !osc_status);

  p_gclk_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_status |-> !osc_gclk_en);

  p_req_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_irq |-> tick_flag_in) and (lock_irq |-> lock_flag_in) and (osc_irq |-> osc_flag));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & 8'h6D) == 8'h00);
endmodule

bind clkstat_irq_regs clkstat_irq_regs_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stop_entry   (stop_entry),
  .tick_flag_in (tick_flag_in),
  .lock_flag_in (lock_flag_in),
  .tick_irq     (tick_irq),
  .lock_irq     (lock_irq),
  .osc_irq      (osc_irq),
  .osc_gclk_en  (osc_gclk_en),
  .osc_status   (osc_status),
  .osc_chg      (osc_chg),
  .osc_flag     (osc_flag),
  .flag_clr     (flag_clr),
  .en_q         (en_q)
);

// File: tb/clkstat_irq_regs_bench.sv
`timescale 1ns/1ps
module clkstat_irq_regs_bench;
  localparam logic [7:0] A_EN   = 8'h38;
  localparam logic [7:0] A_STAT = 8'h37;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       osc_ok_in = 1'b0;
  logic       stop_entry = 1'b0;
  logic       tick_flag_in = 1'b0;
  logic       lock_flag_in = 1'b0;
  logic       tick_irq, lock_irq, osc_irq, osc_gclk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clkstat_irq_regs u_clkstat_irq_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .osc_ok_in(osc_ok_in), .stop_entry(stop_entry),
    .tick_flag_in(tick_flag_in), .lock_flag_in(lock_flag_in),
    .tick_irq(tick_irq), .lock_irq(lock_irq), .osc_irq(osc_irq),
    .osc_gclk_en(osc_gclk_en)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // expected status word: flag at bit 1, qualified status at bit 0
  function automatic logic [7:0] exp_stat(bit f, bit q);
    return {6'b0, f, q};
  endfunction

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(A_EN, rd);   check("R1 enable reset", rd, 8'h00);
    bus_read(A_STAT, rd); check("R1 status reset", rd, 8'h00);
    check("R1 irqs reset", {4'b0, tick_irq, lock_irq, osc_irq, osc_gclk_en}, 8'h00);

    // R2 exhaustive write/readback of enable register
    for (int v = 0; v < 256; v++) begin
      bus_write(A_EN, v[7:0]);
      bus_read(A_EN, rd);
      check("R2 enable readback", rd, v[7:0] & 8'h92);
    end

    // R5/R8/R3 rising change
    osc_ok_in = 1'b1;
    settle(1);
    #1 check("R5 status follows input", bus_rdata & 8'h00, 8'h00);
    bus_read(A_STAT, rd); check("R3 flag set after rise", rd, exp_stat(1, 1));
    check("R8 gate on", {7'b0, osc_gclk_en}, 8'h01);

    // R4 writing zero leaves flag; R5/R10 writes to status and reserved bits ignored
    bus_write(A_STAT, 8'hFD);
    bus_read(A_STAT, rd); check("R4 write 0 no effect / R10 reserved", rd, exp_stat(1, 1));
    bus_write(A_STAT, 8'h02);
    bus_read(A_STAT, rd); check("R4 w1c clears", rd, exp_stat(0, 1));

    // R3 falling change
    osc_ok_in = 1'b0;
    settle(3);
    bus_read(A_STAT, rd); check("R3 flag set after fall", rd, exp_stat(1, 0));
    check("R8 gate off", {7'b0, osc_gclk_en}, 8'h00);
    bus_write(A_STAT, 8'h01);
    bus_read(A_STAT, rd); check("R5 write to status ignored", rd, exp_stat(1, 0));
    bus_write(A_STAT, 8'hFF);
    bus_read(A_STAT, rd); check("R4 clear again", rd, exp_stat(0, 0));

    // R3 latency: flag not yet set one edge after the input change
    @(negedge clk); osc_ok_in = 1'b1;
    @(negedge clk);
    bus_sel = 1'b1; bus_addr = A_STAT; #1;
    check("R3 flag latency", bus_rdata, exp_stat(0, 1));
    bus_sel = 1'b0;
    @(negedge clk);
    bus_sel = 1'b1; #1;
    check("R3 flag after two edges", bus_rdata, exp_stat(1, 1));
    bus_sel = 1'b0;
    bus_write(A_STAT, 8'h02);

    // R9 set wins over clear at the same edge
    @(negedge clk); osc_ok_in = 1'b0;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 8'h02;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    bus_read(A_STAT, rd); check("R9 set wins", rd, exp_stat(1, 0));
    bus_write(A_STAT, 8'h02);

    // R6 stop entry forces status low
    osc_ok_in = 1'b1;
    settle(3);
    bus_write(A_STAT, 8'h02);
    bus_read(A_STAT, rd); check("R6 pre-stop status", rd, exp_stat(0, 1));
    @(negedge clk); stop_entry = 1'b1;
    @(negedge clk);
    bus_sel = 1'b1; bus_addr = A_STAT; #1;
    check("R6 status low in stop", bus_rdata & 8'h01, 8'h00);
    check("R8 gate off in stop", {7'b0, osc_gclk_en}, 8'h00);
    bus_sel = 1'b0;
    settle(2);
    bus_read(A_STAT, rd); check("R6 stop raises flag", rd, exp_stat(1, 0));
    stop_entry = 1'b0;
    settle(3);
    bus_read(A_STAT, rd); check("R6 status returns", rd, exp_stat(1, 1));

    // R7 sweep: enables x tick/lock/osc flags
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < 8; f++) begin
        logic [7:0] ev;
        ev = {e[2], 2'b00, e[1], 2'b00, e[0], 1'b0};
        bus_write(A_EN, ev);
        bus_write(A_STAT, 8'h02);
        if (f[2]) begin
          osc_ok_in = ~osc_ok_in;
          settle(3);
        end
        tick_flag_in = f[0];
        lock_flag_in = f[1];
        #1;
        check("R7 tick irq", {7'b0, tick_irq}, {7'b0, e[2] & f[0]});
        check("R7 lock irq", {7'b0, lock_irq}, {7'b0, e[1] & f[1]});
        check("R7 osc irq",  {7'b0, osc_irq},  {7'b0, e[0] & f[2]});
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule